// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This block monitors a bank of general-purpose input pins (90 by default) and latches every qualifying transition into a sticky per-pin status bit. Each pin has its own rising-edge enable and falling-edge enable. A transition counts only when its direction is enabled for that pin. When both directions are enabled, either direction counts. Every pin is resynchronised to the block clock before edge detection, so asynchronous inputs are safe.

Software reaches the enables and the status bits through a small 32-bit register interface. Reads are combinational. Writes complete in one clock. A status bit is cleared by writing a one to its position, and writing a zero leaves it alone. Status bits drive three level-sensitive interrupt outputs:
- Pin 0 has its own dedicated line.
- Pin 1 has its own dedicated line.
- All remaining pins share one ORed request line.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, all enable registers and all status registers read zero, and all three interrupt outputs are low.
- R2: With the rising enable set for a pin, a 0-to-1 change on that pin sets its status bit. The bit becomes readable on the third rising clock edge after the change.
- R3: With the falling enable set for a pin, a 1-to-0 change sets its status bit with the same latency. With both enables set, either direction sets it.
- R4: A pin change whose direction is not enabled for that pin leaves its status bit at zero.
- R5: A set status bit stays set when the pin returns to its earlier level and no clear is written.
- R6: Writing a one to a status bit position clears that bit. Writing a zero to a status bit position leaves that bit unchanged.
- R7: When a qualifying edge and a clear write hit the same bit on the same clock edge, the bit ends up set.
- R8: `irq_pin0` equals status bit of pin 0, and `irq_pin1` equals status bit of pin 1. Both are level signals that drop once the bit is cleared.
- R9: `irq_shared` is high exactly while any status bit of pins 2 and above is set.
- R10: The register map is as follows:
  - Rising enables are at byte offset 0x00+4k.
  - Falling enables are at 0x20+4k.
  - Status is at 0x48+4k.
  - Bit j of register k belongs to pin 32k+j.
  - Bits with no pin read zero, and unmapped offsets read zero.
- R11: Rising and falling enable registers read back the last value written to their implemented bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_in | input | NUM_PINS | Raw pin levels, asynchronous to clk |
| bus_we | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_pin0 | output | 1 | Dedicated interrupt for pin 0 |
| irq_pin1 | output | 1 | Dedicated interrupt for pin 1 |
| irq_shared | output | 1 | Shared interrupt for pins 2 and above |

## Verification
The bench builds the block with NUM_PINS = 40. This gives two status registers, the second with only eight implemented bits, so the partial-register padding and the register-to-pin mapping are both in reach while a sweep over every single pin stays short.

Each pin is exercised in turn:
- Rising detection, sticky hold, ignored opposite direction, zero-write and one-write clearing are checked against the bench's own bit arithmetic.
- The same sweep is repeated for falling edges.
- The dedicated and shared interrupt outputs are compared with the pin index.

A timed write that coincides with an edge exercises the set-over-clear rule.

// File: rtl/gpio_ed_pkg.sv
package gpio_ed_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned RISE_BASE = 32'h00;
  localparam int unsigned FALL_BASE = 32'h20;
  localparam int unsigned STAT_BASE = 32'h48;

  function automatic int unsigned reg_count(input int unsigned pins);
    return (pins + REG_W - 1) / REG_W;
  endfunction
endpackage

// File: rtl/gpio_ed_sync.sv
module gpio_ed_sync #(
  parameter int unsigned W = 90
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q, meta_d, sync_q, sync_d;

  always_comb begin
    meta_d = raw_in;
    sync_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
    end
  end

  assign sync_out = sync_q;
endmodule

// File: rtl/gpio_ed_edge.sv
module gpio_ed_edge #(
  parameter int unsigned W = 90
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q, prev_d, went_up, went_down;

  always_comb begin
    prev_d    = level;
    went_up   = level & ~prev_q;
    went_down = ~level & prev_q;
    hit       = (went_up & rise_en) | (went_down & fall_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/gpio_ed_regs.sv
module gpio_ed_regs
  import gpio_ed_pkg::*;
#(
  parameter int unsigned NUM_PINS = 90,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0] hit_vec,
  output logic [NUM_PINS-1:0] rise_en,
  output logic [NUM_PINS-1:0] fall_en,
  output logic [NUM_PINS-1:0] stat_q,
  output logic [NUM_PINS-1:0] clr_vec
);
  localparam int unsigned NREG = reg_count(NUM_PINS);
  localparam int unsigned FLAT = NREG * REG_W;

  logic [NREG-1:0]     sel_rise, sel_fall, sel_stat;
  logic [NUM_PINS-1:0] rise_q, fall_q, rise_d, fall_d, stat_d;
  logic                rise_ce, fall_ce, stat_ce;
  logic [FLAT-1:0]     rise_flat, fall_flat, stat_flat;

  // Per-register write decode
  for (genvar k = 0; k < NREG; k++) begin : g_dec
    assign sel_rise[k] = bus_we && (bus_addr == ADDR_W'(RISE_BASE + 4*k));
    assign sel_fall[k] = bus_we && (bus_addr == ADDR_W'(FALL_BASE + 4*k));
    assign sel_stat[k] = bus_we && (bus_addr == ADDR_W'(STAT_BASE + 4*k));
  end

  // Per-pin next state
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
    localparam int unsigned K = i / REG_W;
    localparam int unsigned J = i % REG_W;
    assign rise_d[i]  = sel_rise[K] ? bus_wdata[J] : rise_q[i];
    assign fall_d[i]  = sel_fall[K] ? bus_wdata[J] : fall_q[i];
    assign clr_vec[i] = sel_stat[K] & bus_wdata[J];
  end

  always_comb begin
    stat_d  = (stat_q & ~clr_vec) | hit_vec;
    rise_ce = |sel_rise;
    fall_ce = |sel_fall;
    stat_ce = (|clr_vec) | (|hit_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
    end else begin
      if (rise_ce) rise_q <= rise_d;
      if (fall_ce) fall_q <= fall_d;
      if (stat_ce) stat_q <= stat_d;
    end
  end

  assign rise_en   = rise_q;
  assign fall_en   = fall_q;
  assign rise_flat = FLAT'(rise_q);
  assign fall_flat = FLAT'(fall_q);
  assign stat_flat = FLAT'(stat_q);

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NREG; k++) begin
      if (bus_addr == ADDR_W'(RISE_BASE + 4*k)) bus_rdata = rise_flat[k*REG_W +: REG_W];
      if (bus_addr == ADDR_W'(FALL_BASE + 4*k)) bus_rdata = fall_flat[k*REG_W +: REG_W];
      if (bus_addr == ADDR_W'(STAT_BASE + 4*k)) bus_rdata = stat_flat[k*REG_W +: REG_W];
    end
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_ed_pkg::*;
#(
  parameter int unsigned NUM_PINS = 90,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  output logic                irq_pin0,
  output logic                irq_pin1,
  output logic                irq_shared
);
  logic                rst_meta_q, rst_sync_n;
  logic [NUM_PINS-1:0] level, rise_en, fall_en, hit_vec, stat_q, clr_vec;

  // Reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  gpio_ed_sync #(.W(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .raw_in(pin_in), .sync_out(level)
  );

  gpio_ed_edge #(.W(NUM_PINS)) u_edge (
    .clk(clk), .rst_n(rst_sync_n), .level(level),
    .rise_en(rise_en), .fall_en(fall_en), .hit(hit_vec)
  );

  gpio_ed_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hit_vec(hit_vec),
    .rise_en(rise_en), .fall_en(fall_en), .stat_q(stat_q), .clr_vec(clr_vec)
  );

  assign irq_pin0   = stat_q[0];
  assign irq_pin1   = stat_q[1];
  assign irq_shared = |stat_q[NUM_PINS-1:2];
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int unsigned NUM_PINS = 90
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] stat_q,
  input logic [NUM_PINS-1:0] hit_vec,
  input logic [NUM_PINS-1:0] clr_vec,
  input logic                irq_pin0,
  input logic                irq_shared
);
  // R4
  no_unqualified_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(hit_vec)) == '0));

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_q) & ~$past(clr_vec) & ~stat_q) == '0));

  // R7
  edge_over_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(hit_vec) & ~stat_q) == '0));

  // R8
  irq0_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pin0) |-> $past(hit_vec[0]));

  // R9
  shared_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_shared) |-> $past(|clr_vec[NUM_PINS-1:2]));
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .stat_q(stat_q), .hit_vec(hit_vec),
  .clr_vec(clr_vec), .irq_pin0(irq_pin0), .irq_shared(irq_shared)
);

// File: tb/tb_gpio_edge_irq.sv
`timescale 1ns/1ps
module tb_gpio_edge_irq;
  localparam int unsigned NP = 40;
  localparam int unsigned NR = (NP + 31) / 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          bus_we = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_pin0, irq_pin1, irq_shared;
  int            errors = 0;
  int            checks = 0;

  always #2.5 clk = ~clk;

  gpio_edge_irq #(.NUM_PINS(NP), .ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pin0(irq_pin0), .irq_pin1(irq_pin1), .irq_shared(irq_shared)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // all tasks start and end at a falling clock edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] pin_word(input int p, input int k);
    return (p / 32 == k) ? (32'h1 << (p % 32)) : 32'h0;
  endfunction

  task automatic chk_stat_one(input string tag, input int p);
    logic [31:0] d;
    for (int k = 0; k < NR; k++) begin
      rd(8'(8'h48 + 4*k), d);
      chk(tag, d, (p < 0) ? 32'h0 : pin_word(p, k));
    end
  endtask

  task automatic chk_irqs(input string tag, input int p);
    chk({tag, " irq0"}, {31'b0, irq_pin0}, {31'b0, p == 0});
    chk({tag, " irq1"}, {31'b0, irq_pin1}, {31'b0, p == 1});
    chk({tag, " shared"}, {31'b0, irq_shared}, {31'b0, p >= 2});
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int k = 0; k < NR; k++) begin
      rd(8'(4*k), d);          chk("R1 rise reset", d, 0);
      rd(8'(8'h20 + 4*k), d);  chk("R1 fall reset", d, 0);
    end
    chk_stat_one("R1 stat reset", -1);
    chk_irqs("R1", -1);

    // R11 / R10 readback and padding
    wr(8'h00, 32'hA5A5_5A5A); rd(8'h00, d); chk("R11 rise0", d, 32'hA5A5_5A5A);
    wr(8'h24, 32'hFFFF_FFFF); rd(8'h24, d); chk("R10 fall1 pad", d, 32'h0000_00FF);
    wr(8'h04, 32'h1234_5678); rd(8'h04, d); chk("R10 rise1 pad", d, 32'h0000_0078);
    rd(8'h40, d); chk("R10 unmapped", d, 0);
    rd(8'h4C + 4*NR - 4 + 4, d); chk("R10 past status", d, 0);
    wr(8'h00, 0); wr(8'h04, 0); wr(8'h24, 0);
    rd(8'h24, d); chk("R11 fall1 cleared", d, 0);

    // Rising sweep over every pin: R2 R4 R5 R6 R8 R9
    for (int p = 0; p < NP; p++) begin
      wr(8'(4*(p/32)), pin_word(p, p/32));
      pins[p] = 1'b1; settle();
      chk_stat_one("R2 rise set", p);
      chk_irqs("R8/R9 rise", p);
      pins[p] = 1'b0; settle();
      chk_stat_one("R4/R5 fall ignored, held", p);
      wr(8'(8'h48 + 4*(p/32)), ~pin_word(p, p/32));
      chk_stat_one("R6 zero write no effect", p);
      wr(8'(8'h48 + 4*(p/32)), pin_word(p, p/32));
      chk_stat_one("R6 one write clears", -1);
      chk_irqs("R8/R9 cleared", -1);
      wr(8'(4*(p/32)), 0);
    end

    // Raise all with nothing enabled: R4
    pins = '1; settle();
    chk_stat_one("R4 disabled rise", -1);

    // Falling sweep: R3 R5 R6
    for (int p = 0; p < NP; p++) begin
      wr(8'(8'h20 + 4*(p/32)), pin_word(p, p/32));
      pins[p] = 1'b0; settle();
      chk_stat_one("R3 fall set", p);
      chk_irqs("R8/R9 fall", p);
      pins[p] = 1'b1; settle();
      chk_stat_one("R5 held after rise", p);
      wr(8'(8'h48 + 4*(p/32)), pin_word(p, p/32));
      chk_stat_one("R6 clear after fall", -1);
      wr(8'(8'h20 + 4*(p/32)), 0);
    end
    pins = '0; settle();

    // R9 shared stays high while one contributor remains
    wr(8'h00, 32'h0000_0030);
    pins[4] = 1'b1; pins[5] = 1'b1; settle();
    wr(8'h48, 32'h0000_0010);
    chk("R9 shared one left", {31'b0, irq_shared}, 1);
    wr(8'h48, 32'h0000_0020);
    chk("R9 shared none left", {31'b0, irq_shared}, 0);
    wr(8'h00, 0);
    pins = '0; settle();

    // R3 both directions and R7 edge vs clear on the same edge
    wr(8'h00, 32'h8); wr(8'h20, 32'h8);
    pins[3] = 1'b1; settle();
    rd(8'h48, d); chk("R3 both rise", d, 32'h8);
    pins[3] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'h48; bus_wdata = 32'h8;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
    rd(8'h48, d); chk("R7 edge beats clear", d, 32'h8);
    wr(8'h48, 32'h8);
    rd(8'h48, d); chk("R6 plain clear", d, 0);
    pins[3] = 1'b1; settle();
    rd(8'h48, d); chk("R3 both rise again", d, 32'h8);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule